// File: doc/BRIEF.md
# ADC Channel Sequencer and Trigger Controller

This block is the digital control for an eight-input converter front end. It holds a channel-select field, a single/scan mode bit and a trigger control register. The trigger control register chooses what may start a conversion: a software start bit alone, a timer trigger pulse, or the falling edge of an external trigger pin. The eight inputs form two groups of four. In single mode one input is converted. In scan mode the block sweeps from the first input of the selected group up to the selected input. It repeats the sweep until software clears the start bit.

For each conversion the block drives the analog multiplexer select and a one-cycle start strobe. It then waits for a one-cycle done pulse from the converter. A conversion-end flag reports a finished single conversion or a finished sweep. The converter itself, result storage and interrupts sit outside this block.

The sequencer is a three-state machine. IDLE goes to LAUNCH on any accepted start. LAUNCH drives the strobe and goes to WAIT, or back to IDLE if the start bit is cleared. WAIT goes back to IDLE when a single conversion completes or when the start bit is cleared. WAIT goes to LAUNCH when a scan conversion completes, either advancing to the next input or wrapping to the first input of the group.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle (busy_o = 0), mux_sel_o = 0, end_flag_o = 0, conv_start_o = 0, and trg_rdata reads 8'h3F.
- R2: In single mode (cfg_scan_i = 0), a start converts only input cfg_chan_i (0 to 7), exactly once. busy_o clears after the done pulse, and end_flag_o is set.
- R3: In scan mode (cfg_scan_i = 1), bit 2 of the channel select picks the group (0 = inputs 0..3, 1 = inputs 4..7) and bits 1:0 give the last input of the sweep. Inputs group*4 up to the selected one are converted in ascending order, repeatedly, and end_flag_o is set after each full sweep.
- R4: Trigger control bits 7:6 select the start source: 00 = software only, 01 = timer trigger, 11 = external pin. Code 10 is reserved and enables no hardware start. Bits 5:0 always read as 1 and ignore writes.
- R5: standby_i high returns the trigger control register to 8'h3F.
- R6: A write to the trigger control register while busy_o = 1 is ignored.
- R7: A timer_trig_i pulse starts a conversion only when the source code is 01. Its strobe appears in the cycle after the pulse is sampled.
- R8: A falling edge on ext_trig_n_i starts a conversion only when the source code is 11. The pin passes through two synchroniser flops, so the strobe appears on the third clock edge after the pin falls. A rising edge starts nothing.
- R9: Every strobe lasts exactly one cycle. mux_sel_o holds steady until the done pulse, and the next strobe follows only after a done pulse.
- R10: Software, timer or pin starts that arrive while busy_o = 1 are ignored.
- R11: end_flag_o stays set until flag_clr is pulsed.
- R12: Writing 0 to the start bit (go_we with go_wdata = 0) stops a scan and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby_i | input | 1 | Standby / module stop; resets trigger control register |
| cfg_we | input | 1 | Write strobe for channel select and mode |
| cfg_chan_i | input | 3 | Channel select: bit 2 group, bits 1:0 input in group |
| cfg_scan_i | input | 1 | Mode: 0 single, 1 scan |
| trg_we | input | 1 | Write strobe for trigger control register |
| trg_wdata | input | 8 | Trigger control write data |
| trg_rdata | output | 8 | Trigger control read value |
| go_we | input | 1 | Write strobe for the start bit |
| go_wdata | input | 1 | Start bit value written |
| busy_o | output | 1 | Start bit read value (conversion in progress) |
| flag_clr | input | 1 | Clears the conversion-end flag |
| end_flag_o | output | 1 | Conversion-end flag |
| timer_trig_i | input | 1 | Timer conversion trigger pulse |
| ext_trig_n_i | input | 1 | Asynchronous external trigger pin |
| conv_start_o | output | 1 | One-cycle conversion start strobe |
| mux_sel_o | output | 3 | Analog multiplexer select |
| conv_done_i | input | 1 | One-cycle conversion done pulse |

## Verification
The bench sweeps all eight channel codes in both modes. It checks the exact strobe order against an arithmetic sweep list. A design that started group 1 sweeps at input 0, or that stopped after one sweep, would log the wrong list. Source writes are made both while idle and during a running scan, so a register that took writes while busy, or that let bits 5:0 be written, would read back the wrong value. Timer and pin triggers are applied under each source code and while busy, and the pin strobe is sampled on the exact third edge, so a missing or extra synchroniser stage, or a start taken on the rising edge, would show up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;

    localparam logic [1:0] SRC_SW  = 2'b00;
    localparam logic [1:0] SRC_TMR = 2'b01;
    localparam logic [1:0] SRC_RSV = 2'b10;
    localparam logic [1:0] SRC_EXT = 2'b11;

    localparam int         TRG_W     = 8;
    localparam logic [7:0] TRG_RESET = 8'h3F;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int   STAGES     = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    // sh[0..STAGES-1] synchroniser chain, sh[STAGES] previous synced value
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= {(STAGES+1){IDLE_LEVEL}};
        end else begin
            sh <= {sh[STAGES-1:0], pin_i};
        end
    end

    assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             trg_we,
    input  logic [1:0]       src_wdata,
    input  logic             busy_i,
    input  logic             timer_trig_i,
    input  logic             ext_fall_i,
    output logic [TRG_W-1:0] trg_rdata,
    output logic             hw_start_o
);
    logic [1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= TRG_RESET[7:6];
        end else if (standby_i) begin
            src_q <= TRG_RESET[7:6];
        end else if (trg_we && !busy_i) begin
            src_q <= src_wdata;
        end
    end

    assign trg_rdata  = {src_q, TRG_RESET[5:0]};
    assign hw_start_o = !busy_i &&
                        (((src_q == SRC_TMR) && timer_trig_i) ||
                         ((src_q == SRC_EXT) && ext_fall_i));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int GRP_W = 1,
    parameter int SUB_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic [GRP_W+SUB_W-1:0] cfg_chan_i,
    input  logic                   cfg_scan_i,
    input  logic                   conv_done_i,
    output logic                   busy_o,
    output logic                   conv_start_o,
    output logic [GRP_W+SUB_W-1:0] mux_sel_o,
    output logic                   sweep_end_o
);
    localparam int CH_W = GRP_W + SUB_W;

    seq_state_t       state, nxt;
    logic [CH_W-1:0]  cur;
    logic [SUB_W-1:0] last_sub;
    logic             scan_q;
    logic             at_last;

    assign at_last = (cur[SUB_W-1:0] == last_sub);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_i) nxt = ST_LAUNCH;
            ST_LAUNCH: nxt = stop_i ? ST_IDLE : ST_WAIT;
            ST_WAIT: begin
                if (stop_i)           nxt = ST_IDLE;
                else if (conv_done_i) nxt = scan_q ? ST_LAUNCH : ST_IDLE;
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur      <= '0;
            last_sub <= '0;
            scan_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start_i) begin
                scan_q   <= cfg_scan_i;
                last_sub <= cfg_chan_i[SUB_W-1:0];
                cur      <= cfg_scan_i ? {cfg_chan_i[CH_W-1:SUB_W], {SUB_W{1'b0}}}
                                       : cfg_chan_i;
            end else if (state == ST_WAIT && conv_done_i && !stop_i && scan_q) begin
                cur[SUB_W-1:0] <= at_last ? {SUB_W{1'b0}}
                                          : SUB_W'(cur[SUB_W-1:0] + 1'b1);
            end
        end
    end

    always_comb begin
        busy_o       = (state != ST_IDLE);
        conv_start_o = (state == ST_LAUNCH);
        mux_sel_o    = cur;
        sweep_end_o  = (state == ST_WAIT) && conv_done_i && !stop_i &&
                       (!scan_q || at_last);
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int GRP_W       = 1,
    parameter int SUB_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   standby_i,
    input  logic                   cfg_we,
    input  logic [GRP_W+SUB_W-1:0] cfg_chan_i,
    input  logic                   cfg_scan_i,
    input  logic                   trg_we,
    input  logic [7:0]             trg_wdata,
    output logic [7:0]             trg_rdata,
    input  logic                   go_we,
    input  logic                   go_wdata,
    output logic                   busy_o,
    input  logic                   flag_clr,
    output logic                   end_flag_o,
    input  logic                   timer_trig_i,
    input  logic                   ext_trig_n_i,
    output logic                   conv_start_o,
    output logic [GRP_W+SUB_W-1:0] mux_sel_o,
    input  logic                   conv_done_i
);
    localparam int CH_W = GRP_W + SUB_W;

    logic [CH_W-1:0] chan_q;
    logic            scan_q;
    logic            ext_fall, hw_start, sweep_end;
    logic            unused_rsvd;

    assign unused_rsvd = ^trg_wdata[5:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q     <= '0;
            scan_q     <= 1'b0;
            end_flag_o <= 1'b0;
        end else begin
            if (cfg_we) begin
                chan_q <= cfg_chan_i;
                scan_q <= cfg_scan_i;
            end
            if (sweep_end)     end_flag_o <= 1'b1;
            else if (flag_clr) end_flag_o <= 1'b0;
        end
    end

    adc_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_trig_n_i),
        .fall_o (ext_fall)
    );

    adc_trig_ctrl u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .trg_we       (trg_we),
        .src_wdata    (trg_wdata[7:6]),
        .busy_i       (busy_o),
        .timer_trig_i (timer_trig_i),
        .ext_fall_i   (ext_fall),
        .trg_rdata    (trg_rdata),
        .hw_start_o   (hw_start)
    );

    adc_seq_fsm #(.GRP_W(GRP_W), .SUB_W(SUB_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      ((go_we && go_wdata) || hw_start),
        .stop_i       (go_we && !go_wdata),
        .cfg_chan_i   (chan_q),
        .cfg_scan_i   (scan_q),
        .conv_done_i  (conv_done_i),
        .busy_o       (busy_o),
        .conv_start_o (conv_start_o),
        .mux_sel_o    (mux_sel_o),
        .sweep_end_o  (sweep_end)
    );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            standby_i,
    input logic            busy_o,
    input logic            conv_start_o,
    input logic            conv_done_i,
    input logic [CH_W-1:0] mux_sel_o,
    input logic [7:0]      trg_rdata,
    input logic            end_flag_o,
    input logic            flag_clr
);
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !conv_start_o); // R10

    AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !conv_done_i) |=> $stable(mux_sel_o)); // R9

    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !standby_i) |=> $stable(trg_rdata)); // R6

    AST_STANDBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (trg_rdata == 8'h3F)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag_o && !flag_clr) |=> end_flag_o); // R11
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(GRP_W + SUB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby_i),
    .busy_o       (busy_o),
    .conv_start_o (conv_start_o),
    .conv_done_i  (conv_done_i),
    .mux_sel_o    (mux_sel_o),
    .trg_rdata    (trg_rdata),
    .end_flag_o   (end_flag_o),
    .flag_clr     (flag_clr)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 0, cfg_we = 0, cfg_scan_i = 0, trg_we = 0;
    logic [2:0] cfg_chan_i = 0;
    logic [7:0] trg_wdata = 0, trg_rdata;
    logic       go_we = 0, go_wdata = 0, busy_o, flag_clr = 0, end_flag_o;
    logic       timer_trig_i = 0, ext_trig_n_i = 1, conv_start_o, conv_done_i = 0;
    logic [2:0] mux_sel_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int log_n = 0, cnt = 0;
    int log_ch [0:63];

    always #2 clk = ~clk;

    adc_seq_ctrl uut (.*);

    // converter model: done three cycles after each strobe
    always @(negedge clk) begin
        conv_done_i = 1'b0;
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) conv_done_i = 1'b1;
        end
        if (conv_start_o) begin
            if (log_n < 64) log_ch[log_n] = int'(mux_sel_o);
            log_n = log_n + 1;
            cnt = 3;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go(input logic v);
        go_we = 1; go_wdata = v; tick(1); go_we = 0;
    endtask

    task automatic wr_trg(input logic [7:0] v);
        trg_we = 1; trg_wdata = v; tick(1); trg_we = 0;
    endtask

    task automatic set_cfg(input logic [2:0] c, input logic s);
        cfg_we = 1; cfg_chan_i = c; cfg_scan_i = s; tick(1); cfg_we = 0;
    endtask

    task automatic clr_flag();
        flag_clr = 1; tick(1); flag_clr = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy_o; i++) tick(1);
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 400 && !end_flag_o; i++) tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        check(!busy_o && !conv_start_o && !end_flag_o, "R1 idle/flag", busy_o, 0);
        check(mux_sel_o == 0, "R1 mux", mux_sel_o, 0);
        check(trg_rdata == 8'h3F, "R1 trg", trg_rdata, 8'h3F);

        // R2 single mode, every channel
        for (int c = 0; c < 8; c++) begin
            set_cfg(3'(c), 1'b0);
            log_n = 0;
            go(1'b1);
            wait_idle();
            tick(5);
            check(log_n == 1 && log_ch[0] == c, "R2 single chan", log_ch[0], c);
            check(end_flag_o && !busy_o, "R2 flag", end_flag_o, 1);
            tick(4);
            check(end_flag_o, "R11 flag holds", end_flag_o, 1);
            clr_flag();
            check(!end_flag_o, "R11 flag clear", end_flag_o, 0);
        end

        // R3 scan mode, every channel, two sweeps then R12 stop
        for (int c = 0; c < 8; c++) begin
            automatic int base = (c / 4) * 4;
            automatic int len  = (c % 4) + 1;
            automatic int bad  = 0;
            set_cfg(3'(c), 1'b1);
            log_n = 0;
            go(1'b1);
            wait_flag();
            clr_flag();
            if (c == 5) begin
                wr_trg(8'hC0); // R6 write while busy
                check(trg_rdata == 8'h3F, "R6 locked", trg_rdata, 8'h3F);
            end
            wait_flag();
            go(1'b0);
            tick(1);
            check(!busy_o, "R12 stop", busy_o, 0);
            for (int k = 0; k < 2 * len; k++)
                if (log_ch[k] != base + (k % len)) bad++;
            check(bad == 0, "R3 sweep order", bad, 0);
            check(log_n >= 2 * len && log_n <= 2 * len + 1, "R3 sweep count", log_n, 2 * len);
            tick(8);
            clr_flag();
        end

        // R4 register encoding
        wr_trg(8'h80);
        check(trg_rdata == 8'hBF, "R4 reserved code", trg_rdata, 8'hBF);
        timer_trig_i = 1; tick(1); timer_trig_i = 0; tick(2);
        check(!busy_o, "R4 code10 no start", busy_o, 0);
        wr_trg(8'h00);
        check(trg_rdata == 8'h3F, "R4 low bits", trg_rdata, 8'h3F);

        // R7 timer trigger
        set_cfg(3'd6, 1'b0);
        timer_trig_i = 1; tick(1); timer_trig_i = 0; tick(2);
        check(!busy_o, "R7 timer ignored src00", busy_o, 0);
        wr_trg(8'h40);
        check(trg_rdata == 8'h7F, "R4 timer code", trg_rdata, 8'h7F);
        log_n = 0;
        timer_trig_i = 1; tick(1); timer_trig_i = 0;
        check(conv_start_o && mux_sel_o == 6, "R7 timer strobe", conv_start_o, 1);
        // R10 triggers while busy
        tick(1);
        timer_trig_i = 1; go_we = 1; go_wdata = 1; tick(1);
        timer_trig_i = 0; go_we = 0;
        wait_idle(); tick(5);
        check(log_n == 1 && !busy_o, "R10 ignored while busy", log_n, 1);
        clr_flag();

        // R8 external pin
        tick(2);
        ext_trig_n_i = 0; tick(4); ext_trig_n_i = 1; tick(4);
        check(!busy_o && log_n == 1, "R8 pin ignored src01", log_n, 1);
        wr_trg(8'hC0);
        check(trg_rdata == 8'hFF, "R4 ext code", trg_rdata, 8'hFF);
        timer_trig_i = 1; tick(1); timer_trig_i = 0; tick(2);
        check(!busy_o, "R7 timer ignored src11", busy_o, 0);
        set_cfg(3'd3, 1'b0);
        log_n = 0;
        ext_trig_n_i = 0; tick(2);
        check(!busy_o, "R8 sync latency early", busy_o, 0);
        tick(1);
        check(conv_start_o && mux_sel_o == 3, "R8 pin strobe", conv_start_o, 1);
        wait_idle(); tick(5);
        clr_flag();
        ext_trig_n_i = 1; tick(6);
        check(!busy_o && log_n == 1, "R8 rising no start", log_n, 1);

        // R5 standby
        standby_i = 1; tick(1); standby_i = 0;
        check(trg_rdata == 8'h3F, "R5 standby", trg_rdata, 8'h3F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule